// File: doc/BRIEF.md
# Single-Level Page Translation Unit

This block maps 16-bit virtual addresses onto 16-bit physical addresses through one page table kept in physical memory. Each virtual address is cut into a 7-bit page number (bits 15:9) and a 9-bit offset (bits 8:0), so the space holds 128 pages of 512 bytes. An 8-bit table-base register selects the active table. Software changes the register to switch between address spaces, for example on a process switch or on kernel entry.

For each accepted request, the unit builds the table-entry address without an adder. It places the base register in the upper byte and the page number, shifted left by one, in the lower byte, so entries sit two bytes apart. It issues exactly one read of the 16-bit entry and waits for the read data. Entry bit 0 marks the entry valid. Entry bits 15:9 hold the physical frame number. A valid entry produces a one-cycle response carrying the frame joined to the untouched offset. An invalid entry produces a one-cycle page fault that carries the virtual page number, so a handler knows which page to service.

Top module: `page_xlate`

## Requirements
- R1: After synchronous reset, req_ready is 1, rsp_valid, fault_valid and mem_rd_en are 0, and the base register is 0, so the first translation after reset reads entry address {8'h00, page, 1'b0}.
- R2: In the cycle after a request is accepted (req_valid and req_ready both 1 at a clock edge), mem_rd_en is 1 for exactly one cycle, and mem_rd_addr is {base, vaddr[15:9], 1'b0}.
- R3: When the entry returned with mem_rd_valid has bit 0 = 1, rsp_valid is 1 in the next cycle, and rsp_paddr = {entry[15:9], vaddr[8:0]}.
- R4: When the entry has bit 0 = 0, fault_valid is 1 in the next cycle and fault_page = vaddr[15:9]. rsp_valid stays 0.
- R5: The unit waits any number of cycles for mem_rd_valid. The response or fault lasts exactly one cycle, and req_ready returns to 1 in the cycle after it.
- R6: While a translation is in flight, req_ready is 0, further requests are ignored, and no additional read is issued.
- R7: A base write (base_we) takes effect for the next accepted request only. A write during a translation, or in the same cycle as the acceptance, does not change the entry address of that translation.
- R8: Entry bits 8:1 have no effect on the physical address or on the fault decision.
- R9: Address formation has no carries: base 8'hFF with page 7'h7F gives entry address 16'hFFFE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Unit idle and able to accept a request |
| req_vaddr | input | 16 | Virtual address to translate |
| base_we | input | 1 | Load the table-base register |
| base_wdata | input | 8 | New table-base value |
| mem_rd_en | output | 1 | One-cycle read strobe for a table entry |
| mem_rd_addr | output | 16 | Physical address of the table entry |
| mem_rd_valid | input | 1 | Read data present |
| mem_rd_data | input | 16 | Table entry read from memory |
| rsp_valid | output | 1 | One-cycle strobe: translation succeeded |
| rsp_paddr | output | 16 | Physical address |
| fault_valid | output | 1 | One-cycle strobe: page fault |
| fault_page | output | 7 | Virtual page number that faulted |

## Verification
The hardest case to reach is a base-register change that overlaps an in-flight table read. The register must move while the fetch still uses the address latched at acceptance. The bench writes a new base during the read wait, and also in the very cycle of acceptance. It then checks that the current fetch used the old table and that the following request uses the new one. A long memory latency, with extra request pulses during the wait, shows that the unit neither accepts a second request nor issues a second read while busy.

// File: rtl/pxu_pkg.sv
package pxu_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_DONE  = 2'd2,
    ST_FAULT = 2'd3
  } pxu_state_t;
endpackage

// File: rtl/pxu_base_reg.sv
// Table-base register; loaded at any time, sampled only when a request is accepted.
module pxu_base_reg #(
  parameter int BASE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [BASE_W-1:0] wdata,
  output logic [BASE_W-1:0] base_q
);
  always_ff @(posedge clk) begin
    if (rst) base_q <= '0;
    else if (we) base_q <= wdata;
  end
endmodule

// File: rtl/pxu_addr_form.sv
// Pure field placement: entry address and physical address are built by
// concatenation of power-of-two aligned fields, with no adder in the path.
module pxu_addr_form #(
  parameter int VA_W   = 16,
  parameter int OFFS_W = 9,
  parameter int BASE_W = 8,
  parameter int PTE_W  = 16,
  localparam int PAGE_W = VA_W - OFFS_W,
  localparam int MEM_AW = BASE_W + PAGE_W + 1
) (
  input  logic [BASE_W-1:0] base,
  input  logic [VA_W-1:0]   vaddr,
  input  logic [PAGE_W-1:0] frame,
  input  logic [OFFS_W-1:0] offset,
  output logic [MEM_AW-1:0] pte_addr,
  output logic [VA_W-1:0]   paddr
);
  logic [PAGE_W-1:0] page;

  always_comb begin
    page     = vaddr[VA_W-1:OFFS_W];
    pte_addr = {base, page, 1'b0};
    paddr    = {frame, offset};
  end
endmodule

// File: rtl/pxu_ctrl.sv
// Sequencer: IDLE -> READ (wait for data) -> DONE or FAULT -> IDLE.
module pxu_ctrl
  import pxu_pkg::*;
#(
  parameter int VA_W   = 16,
  parameter int OFFS_W = 9,
  parameter int BASE_W = 8,
  localparam int PAGE_W = VA_W - OFFS_W,
  localparam int MEM_AW = BASE_W + PAGE_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_vaddr,
  output logic              req_ready,
  input  logic [MEM_AW-1:0] pte_addr,
  input  logic [VA_W-1:0]   paddr,
  input  logic              entry_ok,
  output logic [OFFS_W-1:0] offset_q,
  output logic              mem_rd_en,
  output logic [MEM_AW-1:0] mem_rd_addr,
  input  logic              mem_rd_valid,
  output logic              rsp_valid,
  output logic [VA_W-1:0]   rsp_paddr,
  output logic              fault_valid,
  output logic [PAGE_W-1:0] fault_page
);
  pxu_state_t        state;
  logic [PAGE_W-1:0] page_q;
  logic              accept;

  assign accept = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      req_ready   <= 1'b1;
      mem_rd_en   <= 1'b0;
      mem_rd_addr <= '0;
      offset_q    <= '0;
      page_q      <= '0;
      rsp_valid   <= 1'b0;
      rsp_paddr   <= '0;
      fault_valid <= 1'b0;
      fault_page  <= '0;
    end else begin
      mem_rd_en   <= 1'b0;
      rsp_valid   <= 1'b0;
      fault_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            state       <= ST_READ;
            req_ready   <= 1'b0;
            mem_rd_en   <= 1'b1;
            mem_rd_addr <= pte_addr;
            offset_q    <= req_vaddr[OFFS_W-1:0];
            page_q      <= req_vaddr[VA_W-1:OFFS_W];
          end
        end
        ST_READ: begin
          if (mem_rd_valid) begin
            if (entry_ok) begin
              rsp_valid <= 1'b1;
              rsp_paddr <= paddr;
              state     <= ST_DONE;
            end else begin
              fault_valid <= 1'b1;
              fault_page  <= page_q;
              state       <= ST_FAULT;
            end
          end
        end
        default: begin
          state     <= ST_IDLE;
          req_ready <= 1'b1;
        end
      endcase
    end
  end

  assert_accept_reads_R2: assert property (@(posedge clk) disable iff (rst)
    accept |=> mem_rd_en);
  assert_single_read_R2: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |=> !mem_rd_en);
  assert_busy_no_read_R6: assert property (@(posedge clk) disable iff (rst)
    !req_ready |=> !mem_rd_en);
  assert_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
    !(rsp_valid && fault_valid));
  assert_pulse_then_ready_R5: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid || fault_valid) |=> (!rsp_valid && !fault_valid && req_ready));
  assert_result_after_data_R5: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid || fault_valid) |-> $past(mem_rd_valid));
endmodule

// File: rtl/page_xlate.sv
module page_xlate #(
  parameter int VA_W   = 16,
  parameter int OFFS_W = 9,
  parameter int BASE_W = 8,
  parameter int PTE_W  = 16,
  parameter int VALID_BIT = 0,
  localparam int PAGE_W = VA_W - OFFS_W,
  localparam int MEM_AW = BASE_W + PAGE_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic              base_we,
  input  logic [BASE_W-1:0] base_wdata,
  output logic              mem_rd_en,
  output logic [MEM_AW-1:0] mem_rd_addr,
  input  logic              mem_rd_valid,
  input  logic [PTE_W-1:0]  mem_rd_data,
  output logic              rsp_valid,
  output logic [VA_W-1:0]   rsp_paddr,
  output logic              fault_valid,
  output logic [PAGE_W-1:0] fault_page
);
  logic [BASE_W-1:0] base_q;
  logic [MEM_AW-1:0] pte_addr;
  logic [VA_W-1:0]   paddr;
  logic [OFFS_W-1:0] offset_q;
  logic [PAGE_W-1:0] frame;
  logic              entry_ok;
  logic              unused_pte_bits;

  assign frame           = mem_rd_data[PTE_W-1 -: PAGE_W];
  assign entry_ok        = mem_rd_data[VALID_BIT];
  assign unused_pte_bits = ^mem_rd_data;

  pxu_base_reg #(.BASE_W(BASE_W)) u_base (
    .clk(clk), .rst(rst), .we(base_we), .wdata(base_wdata), .base_q(base_q)
  );

  pxu_addr_form #(.VA_W(VA_W), .OFFS_W(OFFS_W), .BASE_W(BASE_W), .PTE_W(PTE_W)) u_form (
    .base(base_q), .vaddr(req_vaddr), .frame(frame), .offset(offset_q),
    .pte_addr(pte_addr), .paddr(paddr)
  );

  pxu_ctrl #(.VA_W(VA_W), .OFFS_W(OFFS_W), .BASE_W(BASE_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_ready(req_ready),
    .pte_addr(pte_addr), .paddr(paddr), .entry_ok(entry_ok), .offset_q(offset_q),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
    .fault_valid(fault_valid), .fault_page(fault_page)
  );

  // R8: the physical address carries only the frame field and the offset
  assert_offset_kept_R8: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_paddr[OFFS_W-1:0] == $past(offset_q)));
endmodule

// File: tb/page_xlate_test.sv
module page_xlate_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 7;
  // {base, vaddr, entry, latency, entry addr, fault, paddr or page}
  localparam logic [87:0] VEC [NV] = '{
    {8'h00, 16'h0000, 16'h0001, 8'd0, 16'h0000, 8'd0, 16'h0000},
    {8'h12, 16'h2A5C, 16'h8E01, 8'd2, 16'h122A, 8'd0, 16'h8E5C},
    {8'h34, 16'hFE10, 16'hFFFE, 8'd1, 16'h34FE, 8'd1, 16'h007F},
    {8'h00, 16'h01FF, 16'h03FF, 8'd3, 16'h0000, 8'd0, 16'h03FF},
    {8'hFF, 16'hFFFF, 16'hFE01, 8'd0, 16'hFFFE, 8'd0, 16'hFFFF},
    {8'h80, 16'h0400, 16'hA5FE, 8'd5, 16'h8004, 8'd1, 16'h0002},
    {8'h07, 16'h6123, 16'h2001, 8'd1, 16'h0760, 8'd0, 16'h2123}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_ready;
  logic [15:0] req_vaddr = '0;
  logic base_we = 1'b0;
  logic [7:0] base_wdata = '0;
  logic mem_rd_en, mem_rd_valid = 1'b0;
  logic [15:0] mem_rd_addr, mem_rd_data = '0;
  logic rsp_valid, fault_valid;
  logic [15:0] rsp_paddr;
  logic [6:0] fault_page;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  page_xlate uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .base_we(base_we), .base_wdata(base_wdata),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid),
    .mem_rd_data(mem_rd_data), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
    .fault_valid(fault_valid), .fault_page(fault_page)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load_base(input logic [7:0] b);
    base_we = 1'b1; base_wdata = b;
    @(posedge clk); @(negedge clk);
    base_we = 1'b0;
  endtask

  // Called at a negedge with the unit idle.
  task automatic xlate(input logic [15:0] va, input logic [15:0] pte, input int lat,
                       input logic [15:0] exp_addr, input bit exp_fault, input logic [15:0] exp_val,
                       input bit poke, input bit mid_we, input logic [7:0] mid_base, input string tag);
    check(req_ready == 1'b1, "R5 ready before request", {31'b0, req_ready}, 1);
    req_valid = 1'b1; req_vaddr = va;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0; req_vaddr = 16'h0; base_we = 1'b0;
    check(mem_rd_en == 1'b1, {tag, " R2 read strobe"}, {31'b0, mem_rd_en}, 1);
    check(mem_rd_addr == exp_addr, {tag, " R2 entry address"}, {16'b0, mem_rd_addr}, {16'b0, exp_addr});
    for (int i = 0; i < lat; i++) begin
      if (poke) begin req_valid = 1'b1; req_vaddr = 16'hBEEF; end
      if (mid_we && i == 0) begin base_we = 1'b1; base_wdata = mid_base; end
      @(posedge clk); @(negedge clk);
      req_valid = 1'b0; base_we = 1'b0;
      check(!mem_rd_en && !rsp_valid && !fault_valid && !req_ready, "R6 busy wait",
            {28'b0, mem_rd_en, rsp_valid, fault_valid, req_ready}, 0);
    end
    mem_rd_valid = 1'b1; mem_rd_data = pte;
    @(posedge clk); @(negedge clk);
    mem_rd_valid = 1'b0; mem_rd_data = 16'h5A5A;
    if (exp_fault) begin
      check(fault_valid && !rsp_valid, {tag, " R4 fault strobe"}, {30'b0, fault_valid, rsp_valid}, 2);
      check(fault_page == exp_val[6:0], {tag, " R4 fault page"}, {25'b0, fault_page}, {25'b0, exp_val[6:0]});
    end else begin
      check(rsp_valid && !fault_valid, {tag, " R3 response strobe"}, {30'b0, rsp_valid, fault_valid}, 2);
      check(rsp_paddr == exp_val, {tag, " R3 physical address"}, {16'b0, rsp_paddr}, {16'b0, exp_val});
    end
    @(posedge clk); @(negedge clk);
    check(!rsp_valid && !fault_valid && req_ready, "R5 one-cycle result",
          {29'b0, rsp_valid, fault_valid, req_ready}, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1: reset state
    check(req_ready && !rsp_valid && !fault_valid && !mem_rd_en, "R1 reset outputs",
          {28'b0, req_ready, rsp_valid, fault_valid, mem_rd_en}, 8);
    // R1: base is zero without any load
    xlate(16'h0C00, 16'h4201, 1, 16'h000C, 0, 16'h4200, 0, 0, 8'h0, "R1");

    // Vector table: R2 R3 R4 R8 R9
    for (int v = 0; v < NV; v++) begin
      load_base(VEC[v][87:80]);
      xlate(VEC[v][79:64], VEC[v][63:48], int'(VEC[v][47:40]), VEC[v][39:24],
            VEC[v][16], VEC[v][15:0], 0, 0, 8'h0, $sformatf("vec%0d", v));
    end

    // R5 long latency, R6 requests while busy are ignored
    load_base(8'h21);
    xlate(16'h1234, 16'h7E01, 20, 16'h2112, 0, 16'h7E34, 1, 0, 8'h0, "R5/R6 long wait");

    // R7: base write during flight keeps the current fetch on the old table
    load_base(8'h10);
    xlate(16'h0200, 16'h0601, 3, 16'h1002, 0, 16'h0600, 0, 1, 8'h55, "R7 mid-flight write");
    xlate(16'h0200, 16'h0801, 0, 16'h5502, 0, 16'h0800, 0, 0, 8'h0, "R7 next request");
    // R7: write in the acceptance cycle applies only afterwards
    base_we = 1'b1; base_wdata = 8'h99;
    xlate(16'h0200, 16'h0000, 2, 16'h5502, 1, 16'h0001, 0, 0, 8'h0, "R7 same-cycle write");
    xlate(16'h0200, 16'h0A01, 1, 16'h9902, 0, 16'h0A00, 0, 0, 8'h0, "R7 after same-cycle write");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule